// File: doc/BRIEF.md
# USB Host Controller Run/Halt and Interrupt Status

This block keeps the run/stop state and the interrupt status flags of a full-speed/low-speed USB host controller. Software reaches it through a small register port with two registers: a command register that holds the run bit and the global-suspend bit, and a 16-bit status register whose flags are cleared by writing ones. The schedule engine, which is outside the block, reports what happens on the bus as single-cycle event pulses. It also drives a level that shows a transaction is still in flight.

Two error classes stop the schedule without software help: a transfer-descriptor consistency failure and a host-side bus-master error. Each one drops the run bit in hardware. The halted flag follows a stop only after the in-flight transaction has drained. A one-cycle frame-counter reset pulse marks each run-to-stop transition, so that the next start begins again from the frame list index. The interrupt line is the OR of the five event flags, each gated by its own enable.

Top module: `hc_run_halt_status`

## Requirements
- R1: After reset the status register reads 0x0020, the command register reads 0x0000, run_o is 0, halted_o is 1, irq_o is 0 and frame_rst_o is 0.
- R2: Status bits 15:6 always read zero. The command register (wr_addr/rd_addr 0) holds only run in bit 0 and global suspend in bit 3; all other command bits read zero.
- R3: A write to the status register (address 1) clears every flag whose data bit is 1. Data bits of 0 leave their flags unchanged. The flag positions are: bit 5 halted, bit 4 process error, bit 3 system error, bit 2 resume, bit 1 error interrupt, bit 0 transfer interrupt.
- R4: A td_fault pulse sets bit 4 and forces run_o to 0 on the next cycle. This holds even if software writes run = 1 in the same cycle.
- R5: A bus_err pulse sets bit 3 and forces run_o to 0 on the next cycle.
- R6: Bit 5 sets at the first clock edge at which run_o is 0 and xact_busy is low. While xact_busy stays high after a stop, bit 5 stays 0.
- R7: A command write with bit 0 = 1 (and no fatal event in the same cycle) clears bit 5 at that edge, so halted_o is 0 on the next cycle.
- R8: frame_rst_o is high for exactly one cycle: the first cycle in which run_o is 0 after being 1. A stop command while already stopped gives no pulse.
- R9: A resume pulse sets bit 2 only while the suspend bit (command bit 3) is 1. Otherwise it has no effect.
- R10: xact_done with td_err set sets bit 1. If td_ioc is also set, bits 1 and 0 are both set.
- R11: xact_done sets bit 0 when td_ioc is set, or when short_pkt and td_spd are both set. A short packet with td_spd = 0 and no IOC sets nothing.
- R12: When a hardware set and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R13: irq_o is the OR over i = 0..4 of status bit i AND irq_en[i]. It stays high until the flags are cleared or their enables are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 command, 1 status |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read target: 0 command, 1 status |
| rd_data | output | DATA_W | Read data of the selected register |
| xact_done | input | 1 | Transaction completion pulse |
| td_ioc | input | 1 | Completed TD asked for an interrupt on completion |
| td_spd | input | 1 | Completed TD has short-packet detection enabled |
| short_pkt | input | 1 | Completed transaction returned a short packet |
| td_err | input | 1 | Completed transaction ended in error |
| td_fault | input | 1 | TD consistency failure pulse |
| bus_err | input | 1 | Host-side bus-master error pulse |
| resume | input | 1 | Device resume signalling seen |
| xact_busy | input | 1 | A transaction is in flight |
| irq_en | input | 5 | Per-flag interrupt enables for bits 4:0 |
| run_o | output | 1 | Current run/stop state |
| halted_o | output | 1 | Controller has halted |
| frame_rst_o | output | 1 | One-cycle frame-counter reset pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a hardware flag set and a software write-1 clear of that same flag: the bench raises a transaction error in the same cycle as a status write that clears bit 1, and then expects bit 1 to read back as set. The second pair is a fatal-error stop and a software run command: the bench pulses td_fault while it writes run = 1, and expects run_o low, a frame reset pulse, and the halted flag set one cycle later.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int FLAG_XFER  = 0;
  localparam int FLAG_ERR   = 1;
  localparam int FLAG_RSM   = 2;
  localparam int FLAG_SYS   = 3;
  localparam int FLAG_PROC  = 4;
  localparam int FLAG_HALT  = 5;
  localparam int NUM_FLAGS  = 6;
  localparam int NUM_IRQ    = 5;
  localparam int CMD_RUN    = 0;
  localparam int CMD_SUSP   = 3;

  typedef enum logic {
    SEL_CMD  = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/hcs_rst_sync.sv
module hcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hcs_flag_bank.sv
module hcs_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_r;

  // set wins over clear (R12)
  always_comb begin
    q_d = q_r;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RST_VAL;
    else        q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

module hcs_flag_bank #(
  parameter int NB       = 6,
  parameter int HALT_POS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic [NB-1:0] clr_vec,
  output logic [NB-1:0] flags
);
  for (genvar i = 0; i < NB; i++) begin : g_flag
    localparam logic RV = (i == HALT_POS) ? 1'b1 : 1'b0;
    hcs_flag_cell #(.RST_VAL(RV)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flags[i])
    );
  end
endmodule

// File: rtl/hcs_run_ctrl.sv
module hcs_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic wr_run,
  input  logic wr_susp,
  input  logic hw_stop,
  input  logic xact_busy,
  output logic run_o,
  output logic susp_o,
  output logic frame_rst_o,
  output logic halt_set_o,
  output logic halt_clr_o
);
  logic run_q, run_d;
  logic susp_q, susp_d;
  logic frst_q, frst_d;
  logic start;

  always_comb begin
    run_d  = run_q;
    susp_d = susp_q;
    if (cmd_wr) begin
      run_d  = wr_run;
      susp_d = wr_susp;
    end
    if (hw_stop) run_d = 1'b0;
    frst_d = run_q & ~run_d;
    start  = cmd_wr & wr_run & ~hw_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      susp_q <= 1'b0;
      frst_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      susp_q <= susp_d;
      frst_q <= frst_d;
    end
  end

  assign run_o       = run_q;
  assign susp_o      = susp_q;
  assign frame_rst_o = frst_q;
  assign halt_set_o  = ~run_q & ~xact_busy & ~start;
  assign halt_clr_o  = start;
endmodule

// File: rtl/hc_run_halt_status.sv
module hc_run_halt_status
  import hcs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              xact_done,
  input  logic              td_ioc,
  input  logic              td_spd,
  input  logic              short_pkt,
  input  logic              td_err,
  input  logic              td_fault,
  input  logic              bus_err,
  input  logic              resume,
  input  logic              xact_busy,
  input  logic [4:0]        irq_en,
  output logic              run_o,
  output logic              halted_o,
  output logic              frame_rst_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  logic rst_sync_n;
  logic cmd_wr, stat_wr;
  logic susp;
  logic halt_set, halt_clr;
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flags;
  logic unused_wr_hi;

  hcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cmd_wr  = wr_en & (reg_sel_e'(wr_addr) == SEL_CMD);
  assign stat_wr = wr_en & (reg_sel_e'(wr_addr) == SEL_STAT);
  assign unused_wr_hi = ^wr_data[DATA_W-1:NUM_FLAGS];

  hcs_run_ctrl u_run (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_wr      (cmd_wr),
    .wr_run      (wr_data[CMD_RUN]),
    .wr_susp     (wr_data[CMD_SUSP]),
    .hw_stop     (td_fault | bus_err),
    .xact_busy   (xact_busy),
    .run_o       (run_o),
    .susp_o      (susp),
    .frame_rst_o (frame_rst_o),
    .halt_set_o  (halt_set),
    .halt_clr_o  (halt_clr)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_XFER] = xact_done & (td_ioc | (short_pkt & td_spd));
    set_vec[FLAG_ERR]  = xact_done & td_err;
    set_vec[FLAG_RSM]  = resume & susp;
    set_vec[FLAG_SYS]  = bus_err;
    set_vec[FLAG_PROC] = td_fault;
    set_vec[FLAG_HALT] = halt_set;
    clr_vec            = stat_wr ? wr_data[NUM_FLAGS-1:0] : '0;
    clr_vec[FLAG_HALT] = clr_vec[FLAG_HALT] | halt_clr;
  end

  hcs_flag_bank #(.NB(NUM_FLAGS), .HALT_POS(FLAG_HALT)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  always_comb begin
    rd_data = '0;
    if (reg_sel_e'(rd_addr) == SEL_STAT) begin
      rd_data = {{PAD_W{1'b0}}, flags};
    end else begin
      rd_data[CMD_RUN]  = run_o;
      rd_data[CMD_SUSP] = susp;
    end
  end

  assign halted_o = flags[FLAG_HALT];
  assign irq_o    = |(flags[NUM_IRQ-1:0] & irq_en);
endmodule

// File: rtl/hcs_checker.sv
module hcs_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              td_fault,
  input logic              bus_err,
  input logic              xact_busy,
  input logic [4:0]        irq_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              run_o,
  input logic              halted_o,
  input logic              frame_rst_o,
  input logic              irq_o
);
  // R4 and R5: fatal events stop the schedule
  p_fatal_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (td_fault || bus_err) |=> !run_o);

  p_halt_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_o) |-> ($past(!run_o) && $past(!xact_busy)));

  p_start_clears_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && wr_data[0] && !td_fault && !bus_err) |=> !halted_o);

  p_frame_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_o) |-> frame_rst_o);

  p_frame_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst_o |=> !frame_rst_o);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:6] == '0);

  p_irq_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_en) |=> (irq_o || !$stable(irq_en)));
endmodule

bind hc_run_halt_status hcs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .td_fault    (td_fault),
  .bus_err     (bus_err),
  .xact_busy   (xact_busy),
  .irq_en      (irq_en),
  .rd_data     (rd_data),
  .run_o       (run_o),
  .halted_o    (halted_o),
  .frame_rst_o (frame_rst_o),
  .irq_o       (irq_o)
);

// File: tb/hc_run_halt_status_test.sv
`timescale 1ns/1ps
module hc_run_halt_status_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        xact_done, td_ioc, td_spd, short_pkt, td_err;
  logic        td_fault, bus_err, resume, xact_busy;
  logic [4:0]  irq_en;
  logic        run_o, halted_o, frame_rst_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hc_run_halt_status uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .xact_done(xact_done), .td_ioc(td_ioc), .td_spd(td_spd),
    .short_pkt(short_pkt), .td_err(td_err), .td_fault(td_fault),
    .bus_err(bus_err), .resume(resume), .xact_busy(xact_busy),
    .irq_en(irq_en), .run_o(run_o), .halted_o(halted_o),
    .frame_rst_o(frame_rst_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic done(input logic ioc, input logic spd, input logic sh, input logic err);
    xact_done = 1'b1; td_ioc = ioc; td_spd = spd; short_pkt = sh; td_err = err;
    step();
    xact_done = 1'b0; td_ioc = 1'b0; td_spd = 1'b0; short_pkt = 1'b0; td_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(1'b1, v); chk("R1 status", v, 16'h0020);
    rd(1'b0, v); chk("R1 command", v, 16'h0000);
    chk("R1 run", {15'd0, run_o}, 16'd0);
    chk("R1 halted", {15'd0, halted_o}, 16'd1);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    chk("R1 frame_rst", {15'd0, frame_rst_o}, 16'd0);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    wr(1'b1, 16'hFFC0);
    rd(1'b1, v); chk("R2 status upper write", v, 16'h0020);
    wr(1'b0, 16'hFFF6);
    rd(1'b0, v); chk("R2 command other bits", v, 16'h0000);
    wr(1'b0, 16'h0008);
    rd(1'b0, v); chk("R2 suspend bit", v, 16'h0008);
    wr(1'b0, 16'h0000);
  endtask

  task automatic t_start();
    logic [15:0] v;
    wr(1'b0, 16'h0001);
    chk("R7 run", {15'd0, run_o}, 16'd1);
    chk("R7 halted cleared", {15'd0, halted_o}, 16'd0);
    rd(1'b1, v); chk("R7 status", v, 16'h0000);
  endtask

  task automatic t_err_ioc();
    logic [15:0] v;
    done(1'b0, 1'b0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R10 error only", v, 16'h0002);
    wr(1'b1, 16'h0002);
    done(1'b1, 1'b0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R10 error with ioc", v, 16'h0003);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    wr(1'b1, 16'h0000);
    rd(1'b1, v); chk("R3 write zero", v, 16'h0003);
    wr(1'b1, 16'h0001);
    rd(1'b1, v); chk("R3 clear bit0", v, 16'h0002);
    wr(1'b1, 16'h0002);
    rd(1'b1, v); chk("R3 clear bit1", v, 16'h0000);
  endtask

  task automatic t_short();
    logic [15:0] v;
    done(1'b0, 1'b0, 1'b1, 1'b0);
    rd(1'b1, v); chk("R11 short no spd", v, 16'h0000);
    done(1'b0, 1'b1, 1'b1, 1'b0);
    rd(1'b1, v); chk("R11 short with spd", v, 16'h0001);
    wr(1'b1, 16'h0001);
    done(1'b1, 1'b0, 1'b0, 1'b0);
    rd(1'b1, v); chk("R11 ioc only", v, 16'h0001);
    wr(1'b1, 16'h0001);
  endtask

  task automatic t_resume();
    logic [15:0] v;
    resume = 1'b1; step(); resume = 1'b0;
    rd(1'b1, v); chk("R9 resume not suspended", v, 16'h0000);
    wr(1'b0, 16'h0009);
    resume = 1'b1; step(); resume = 1'b0;
    rd(1'b1, v); chk("R9 resume suspended", v, 16'h0004);
    wr(1'b1, 16'h0004);
    wr(1'b0, 16'h0001);
  endtask

  task automatic t_prio();
    logic [15:0] v;
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'h0002;
    xact_done = 1'b1; td_err = 1'b1;
    step();
    wr_en = 1'b0; wr_data = '0; xact_done = 1'b0; td_err = 1'b0;
    rd(1'b1, v); chk("R12 set beats clear", v, 16'h0002);
  endtask

  task automatic t_irq();
    irq_en = 5'b00000; #1;
    chk("R13 masked", {15'd0, irq_o}, 16'd0);
    irq_en = 5'b00010; #1;
    chk("R13 enabled source", {15'd0, irq_o}, 16'd1);
    irq_en = 5'b11101; #1;
    chk("R13 other enables", {15'd0, irq_o}, 16'd0);
    irq_en = 5'b11111; step();
    chk("R13 held", {15'd0, irq_o}, 16'd1);
    wr(1'b1, 16'h0002);
    chk("R13 cleared", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_td_fault();
    logic [15:0] v;
    td_fault = 1'b1; wr_en = 1'b1; wr_addr = 1'b0; wr_data = 16'h0001;
    step();
    td_fault = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R4 run cleared", {15'd0, run_o}, 16'd0);
    rd(1'b1, v); chk("R4 status", v, 16'h0010);
    chk("R8 pulse on fault stop", {15'd0, frame_rst_o}, 16'd1);
    chk("R4 irq", {15'd0, irq_o}, 16'd1);
    step();
    chk("R8 pulse one cycle", {15'd0, frame_rst_o}, 16'd0);
    rd(1'b1, v); chk("R6 halt after idle", v, 16'h0030);
    wr(1'b1, 16'h0010);
    rd(1'b1, v); chk("R3 clear proc err", v, 16'h0020);
  endtask

  task automatic t_bus_err();
    logic [15:0] v;
    wr(1'b0, 16'h0001);
    bus_err = 1'b1; step(); bus_err = 1'b0;
    chk("R5 run cleared", {15'd0, run_o}, 16'd0);
    rd(1'b1, v); chk("R5 status", v, 16'h0008);
    step();
    wr(1'b1, 16'h0008);
    rd(1'b1, v); chk("R5 after clear", v, 16'h0020);
  endtask

  task automatic t_halt_wait();
    logic [15:0] v;
    wr(1'b0, 16'h0001);
    xact_busy = 1'b1;
    wr(1'b0, 16'h0000);
    chk("R8 pulse on sw stop", {15'd0, frame_rst_o}, 16'd1);
    chk("R6 not halted while busy", {15'd0, halted_o}, 16'd0);
    step();
    step();
    chk("R6 still busy", {15'd0, halted_o}, 16'd0);
    chk("R8 no repeat", {15'd0, frame_rst_o}, 16'd0);
    xact_busy = 1'b0;
    step();
    chk("R6 halted after drain", {15'd0, halted_o}, 16'd1);
    rd(1'b1, v); chk("R6 status", v, 16'h0020);
    wr(1'b0, 16'h0000);
    chk("R8 no pulse when stopped", {15'd0, frame_rst_o}, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b1;
    xact_done = 1'b0; td_ioc = 1'b0; td_spd = 1'b0; short_pkt = 1'b0; td_err = 1'b0;
    td_fault = 1'b0; bus_err = 1'b0; resume = 1'b0; xact_busy = 1'b0;
    irq_en = 5'b11111;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_reserved();
    t_start();
    t_err_ioc();
    t_w1c();
    t_short();
    t_resume();
    t_prio();
    t_irq();
    t_td_fault();
    t_bus_err();
    t_halt_wait();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule